// File: doc/BRIEF.md
# Vertical Element Row Accumulator

This block sits behind a line binarizer in a video capture path. For every scan line the binarizer delivers a short run of words, and each bit in those words marks one horizontal picture element as lit or dark. The block stacks a host-chosen number of consecutive scan lines into one row of picture elements. A bit in the finished row is set when the matching bit was set in any line of that group. The partial row is kept in a small synchronous-read memory. The first line of a group overwrites the stored row. Each later line is ORed into it, and on the last line of the group the merged words are pushed into a row-sized output queue. From there they leave in element order through a valid/ready handshake.

Field and line timing come from two blanking levels. A field begins when vertical blanking falls. The block drops the first scan line of each field and keeps a bounded number of active lines after it. It also handles only every other field. A host start command arms the block, and processing begins at the next field start. A stop command returns the block to idle at once.

Top module: `vra_row_accum`

## Requirements
- R1: After reset the block is idle and `out_valid` is 0.
- R2: A start pulse with the block idle arms it, and processing begins only at the next falling edge of `vblank`. Lines that arrive before that edge produce no output. A stop pulse returns the block to idle, and later lines produce no output.
- R3: The first scan line of every handled field (the line before the first counted `hblank` rise after `vblank` falls) never contributes to any row.
- R4: The first field after arming is handled. After that, handled and skipped fields alternate at each falling edge of `vblank`. A skipped field produces no output.
- R5: `lines_per_elem` is captured on the start pulse, and a value of 0 is taken as 1. Changes on the pin while the block runs have no effect. Each output row is the bitwise OR of that many consecutive accepted lines, word by word.
- R6: The first line of a row overwrites the stored partial row, so nothing carries over from the previous row.
- R7: A row is emitted only after its last line. A partial row left open at a field start is discarded, and the next field starts a new row.
- R8: At most ACTIVE_LINES lines after the skipped first line are accepted in a field. Later lines are ignored.
- R9: The line count advances once per rising edge of `hblank`, however long `hblank` stays high. It does not change while `vblank` is high.
- R10: Row words leave in element order (word 0 first, where word k of a line is the k-th `in_valid` word after the line began). `out_word` holds steady while `out_valid` is high and `out_ready` is low. A full row of ROW_WORDS words is held without loss while the host stalls.
- R11: Words beyond the first ROW_WORDS of a line are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cmd | input | 1 | Host pulse: arm and capture lines per element |
| stop_cmd | input | 1 | Host pulse: return to idle |
| lines_per_elem | input | LPE_W | Scan lines merged into one element row |
| hblank | input | 1 | Horizontal blanking level |
| vblank | input | 1 | Vertical blanking level |
| in_valid | input | 1 | A binarized line word is present |
| in_word | input | WORD_W | Binarized line word, one bit per element |
| out_valid | output | 1 | A row word is available |
| out_word | output | WORD_W | Row word, in element order |
| out_ready | input | 1 | Host accepts the row word |

## Verification
The bench builds the block with 8-bit words, four words per row, a 4-bit lines-per-element field and only six active lines per field. The short field lets the line cut-off of R8 be reached with a handful of lines, and the four-word row lets one line both fill the output queue completely and overrun the row width. Two-line grouping with chosen bit patterns shows the OR merge, the overwrite at a new row, and the discarding of a partial row at a field boundary.

// File: rtl/vra_pkg.sv
package vra_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } vra_state_e;

endpackage

// File: rtl/vra_line_timing.sv
module vra_line_timing
  import vra_pkg::*;
#(
  parameter int ACTIVE_LINES = 240,
  parameter int LPE_W        = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic [LPE_W-1:0] lpe_cfg,
  input  logic             hblank,
  input  logic             vblank,
  output logic             line_break,
  output logic             line_accept,
  output logic             row_first,
  output logic             row_last
);

  localparam int                LN_W   = $clog2(ACTIVE_LINES + 2);
  localparam logic [LN_W-1:0]   LN_MAX = LN_W'(ACTIVE_LINES);
  localparam logic [LPE_W-1:0]  LPE_ONE = LPE_W'(1);

  vra_state_e        state_q;
  logic              field_on_q;
  logic [LPE_W-1:0]  lpe_q;
  logic [LN_W-1:0]   line_no_q;
  logic [LPE_W-1:0]  sub_q;
  logic              hb_q;
  logic              vb_q;

  logic hb_rise;
  logic hb_count;
  logic vb_fall;
  logic in_window;

  assign hb_rise   = hblank & ~hb_q;
  assign hb_count  = hb_rise & ~vblank;
  assign vb_fall   = vb_q & ~vblank;
  assign in_window = (line_no_q != '0) && (line_no_q <= LN_MAX);

  // Control state and field parity
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      field_on_q <= 1'b0;
      lpe_q      <= LPE_ONE;
      hb_q       <= 1'b0;
      vb_q       <= 1'b0;
    end else begin
      hb_q <= hblank;
      vb_q <= vblank;
      if (stop_cmd) begin
        state_q    <= ST_IDLE;
        field_on_q <= 1'b0;
      end else if (start_cmd && state_q == ST_IDLE) begin
        state_q <= ST_ARMED;
        lpe_q   <= (lpe_cfg == '0) ? LPE_ONE : lpe_cfg;
      end else if (state_q == ST_ARMED && vb_fall) begin
        state_q    <= ST_RUN;
        field_on_q <= 1'b1;
      end else if (state_q == ST_RUN && vb_fall) begin
        field_on_q <= ~field_on_q;
      end
    end
  end

  // Line position within the field and within the element row
  always_ff @(posedge clk) begin
    if (rst) begin
      line_no_q <= '0;
      sub_q     <= '0;
    end else if (vb_fall) begin
      line_no_q <= '0;
      sub_q     <= '0;
    end else if (hb_count) begin
      if (in_window) begin
        sub_q <= row_last ? '0 : sub_q + LPE_ONE;
      end
      if (line_no_q <= LN_MAX) begin
        line_no_q <= line_no_q + LN_W'(1);
      end
    end
  end

  assign line_break  = hb_rise;
  assign line_accept = (state_q == ST_RUN) && field_on_q && !vblank && in_window;
  assign row_first   = (sub_q == '0);
  assign row_last    = (sub_q == lpe_q - LPE_ONE);

  AST_FROZEN_IN_VBLANK: assert property (@(posedge clk) disable iff (rst)
    vblank |=> $stable(line_no_q)); // R9

  AST_ONCE_PER_BLANK: assert property (@(posedge clk) disable iff (rst)
    (hblank && hb_q && !vb_fall) |=> ($stable(line_no_q) && $stable(sub_q))); // R9

endmodule

// File: rtl/vra_row_mem.sv
module vra_row_mem #(
  parameter int DEPTH = 8,
  parameter int W     = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/vra_out_fifo.sv
module vra_out_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);

  localparam int               PW      = $clog2(DEPTH);
  localparam int               CW      = $clog2(DEPTH + 1);
  localparam logic [PW-1:0]    PTR_END = PW'(DEPTH - 1);
  localparam logic [CW-1:0]    CNT_MAX = CW'(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr_q;
  logic [PW-1:0] rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          pop;
  logic          full;

  assign pop       = out_valid && out_ready;
  assign full      = (count_q == CNT_MAX);
  assign out_valid = (count_q != '0);
  assign out_data  = store[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (push) begin
      store[wr_ptr_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push) begin
        wr_ptr_q <= (wr_ptr_q == PTR_END) ? '0 : wr_ptr_q + PW'(1);
      end
      if (pop) begin
        rd_ptr_q <= (rd_ptr_q == PTR_END) ? '0 : rd_ptr_q + PW'(1);
      end
      case ({push, pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop)); // R10

  AST_HOLD_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

endmodule

// File: rtl/vra_row_accum.sv
module vra_row_accum #(
  parameter int WORD_W       = 16,
  parameter int ROW_WORDS    = 8,
  parameter int ACTIVE_LINES = 240,
  parameter int LPE_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic [LPE_W-1:0]  lines_per_elem,
  input  logic              hblank,
  input  logic              vblank,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  input  logic              out_ready
);

  localparam int                ADDR_W    = $clog2(ROW_WORDS);
  localparam int                IDX_W     = $clog2(ROW_WORDS + 1);
  localparam logic [IDX_W-1:0]  IDX_LIMIT = IDX_W'(ROW_WORDS);

  logic              line_break;
  logic              line_accept;
  logic              row_first;
  logic              row_last;

  logic [IDX_W-1:0]  widx_q;
  logic              take;

  logic              s1_valid_q;
  logic [ADDR_W-1:0] s1_addr_q;
  logic [WORD_W-1:0] s1_word_q;
  logic              s1_first_q;
  logic              s1_last_q;

  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] merged;
  logic              push;

  vra_line_timing #(
    .ACTIVE_LINES (ACTIVE_LINES),
    .LPE_W        (LPE_W)
  ) u_timing (
    .clk         (clk),
    .rst         (rst),
    .start_cmd   (start_cmd),
    .stop_cmd    (stop_cmd),
    .lpe_cfg     (lines_per_elem),
    .hblank      (hblank),
    .vblank      (vblank),
    .line_break  (line_break),
    .line_accept (line_accept),
    .row_first   (row_first),
    .row_last    (row_last)
  );

  // Word position inside the current scan line
  always_ff @(posedge clk) begin
    if (rst || vblank || line_break) begin
      widx_q <= '0;
    end else if (in_valid && widx_q != IDX_LIMIT) begin
      widx_q <= widx_q + IDX_W'(1);
    end
  end

  assign take = in_valid && line_accept && (widx_q < IDX_LIMIT);

  // Stage 1: the stored partial word arrives from memory
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid_q <= 1'b0;
      s1_addr_q  <= '0;
      s1_word_q  <= '0;
      s1_first_q <= 1'b0;
      s1_last_q  <= 1'b0;
    end else begin
      s1_valid_q <= take;
      s1_addr_q  <= widx_q[ADDR_W-1:0];
      s1_word_q  <= in_word;
      s1_first_q <= row_first;
      s1_last_q  <= row_last;
    end
  end

  vra_row_mem #(
    .DEPTH (ROW_WORDS),
    .W     (WORD_W)
  ) u_row_mem (
    .clk   (clk),
    .we    (s1_valid_q),
    .waddr (s1_addr_q),
    .wdata (merged),
    .re    (take),
    .raddr (widx_q[ADDR_W-1:0]),
    .rdata (rd_word)
  );

  assign merged = s1_first_q ? s1_word_q : (s1_word_q | rd_word);
  assign push   = s1_valid_q && s1_last_q;

  vra_out_fifo #(
    .DEPTH (ROW_WORDS),
    .W     (WORD_W)
  ) u_out_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (merged),
    .out_valid (out_valid),
    .out_data  (out_word),
    .out_ready (out_ready)
  );

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> !out_valid); // R1

  AST_NO_TAKE_IN_VBLANK: assert property (@(posedge clk) disable iff (rst)
    vblank |=> !s1_valid_q); // R9

endmodule

// File: tb/vra_row_accum_bench.sv
`timescale 1ns/1ps
module vra_row_accum_bench;

  localparam int WORD_W       = 8;
  localparam int ROW_WORDS    = 4;
  localparam int ACTIVE_LINES = 6;
  localparam int LPE_W        = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_cmd = 1'b0;
  logic              stop_cmd = 1'b0;
  logic [LPE_W-1:0]  lines_per_elem = '0;
  logic              hblank = 1'b0;
  logic              vblank = 1'b0;
  logic              in_valid = 1'b0;
  logic [WORD_W-1:0] in_word = '0;
  logic              out_valid;
  logic [WORD_W-1:0] out_word;
  logic              out_ready = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [WORD_W-1:0] got [$];
  logic [WORD_W-1:0] exp [$];

  always #2 clk = ~clk;

  vra_row_accum #(
    .WORD_W       (WORD_W),
    .ROW_WORDS    (ROW_WORDS),
    .ACTIVE_LINES (ACTIVE_LINES),
    .LPE_W        (LPE_W)
  ) u_vra_row_accum (
    .clk            (clk),
    .rst            (rst),
    .start_cmd      (start_cmd),
    .stop_cmd       (stop_cmd),
    .lines_per_elem (lines_per_elem),
    .hblank         (hblank),
    .vblank         (vblank),
    .in_valid       (in_valid),
    .in_word        (in_word),
    .out_valid      (out_valid),
    .out_word       (out_word),
    .out_ready      (out_ready)
  );

  // Collect every accepted output word, sampled away from the clock edge
  always @(negedge clk) begin
    #1;
    if (!rst && out_valid && out_ready) got.push_back(out_word);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] want);
    n_checks++;
    if (act !== want) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, want);
    end
  endtask

  task automatic send_line(input logic [39:0] words, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = words[8*i +: 8];
    end
    @(negedge clk);
    in_valid = 1'b0;
    hblank   = 1'b1;
    tick(3);
    hblank   = 1'b0;
    tick(1);
  endtask

  task automatic new_field();
    @(negedge clk);
    vblank = 1'b1;
    tick(2);
    hblank = 1'b1;
    tick(2);
    hblank = 1'b0;
    tick(1);
    hblank = 1'b1;
    tick(1);
    hblank = 1'b0;
    tick(2);
    vblank = 1'b0;
    tick(2);
  endtask

  task automatic cmd_start(input logic [LPE_W-1:0] lpe);
    @(negedge clk);
    lines_per_elem = lpe;
    start_cmd      = 1'b1;
    @(negedge clk);
    start_cmd      = 1'b0;
  endtask

  task automatic cmd_stop();
    @(negedge clk);
    stop_cmd = 1'b1;
    @(negedge clk);
    stop_cmd = 1'b0;
  endtask

  task automatic expect_row(input logic [31:0] v);
    for (int i = 0; i < ROW_WORDS; i++) exp.push_back(v[8*i +: 8]);
  endtask

  task automatic check_outputs(input string tag);
    tick(12);
    check_eq({tag, " word count"}, got.size(), exp.size());
    for (int i = 0; i < exp.size(); i++) begin
      if (i < got.size()) check_eq({tag, " word"}, got[i], exp[i]);
    end
    got.delete();
    exp.delete();
  endtask

  task automatic t_reset();
    check_eq("R1 out_valid after reset", out_valid, 0);
  endtask

  task automatic t_wait_for_field();
    new_field();
    send_line(40'h0011223344, 4);
    send_line(40'h0055667788, 4);
    check_outputs("R2 idle gives nothing");
    cmd_start(4'd1);
    send_line(40'h0011223344, 4);
    send_line(40'h0055667788, 4);
    check_outputs("R2 armed waits for field");
  endtask

  task automatic t_single_lines();
    new_field();
    send_line(40'h00FFFFFFFF, 4);          // R3 skipped first line
    send_line(40'h0004030201, 4);
    expect_row(32'h04030201);
    send_line(40'h0040302010, 4);
    expect_row(32'h40302010);              // R6 overwrite with one line per row
    check_outputs("R3 R5 R9 single-line rows");
  endtask

  task automatic t_skipped_field();
    new_field();
    send_line(40'h0001010101, 4);
    send_line(40'h0002020202, 4);
    send_line(40'h0003030303, 4);
    check_outputs("R4 alternate field skipped");
  endtask

  task automatic t_pairs();
    cmd_stop();
    cmd_start(4'd2);
    @(negedge clk);
    lines_per_elem = 4'd1;                 // R5 pin change ignored while running
    new_field();
    send_line(40'h00FFFFFFFF, 4);
    send_line(40'h0008040201, 4);
    send_line(40'h0080402010, 4);
    expect_row(32'h88442211);              // R5 OR of two lines
    send_line(40'h000000000F, 4);
    send_line(40'h00000000F0, 4);
    expect_row(32'h000000FF);              // R6 new row overwrites
    send_line(40'h00AAAAAAAA, 4);          // R7 partial row left open
    check_outputs("R5 R6 two-line rows");
    new_field();
    send_line(40'h0012345678, 4);
    check_outputs("R4 skipped field in pair mode");
    new_field();
    send_line(40'h00FFFFFFFF, 4);
    send_line(40'h0000000001, 4);
    send_line(40'h0000000100, 4);
    expect_row(32'h00000101);
    check_outputs("R7 partial row discarded");
  endtask

  task automatic t_line_limit();
    cmd_stop();
    cmd_start(4'd1);
    new_field();
    send_line(40'h00FFFFFFFF, 4);
    for (int k = 1; k <= 8; k++) begin
      send_line({8'h00, {4{8'(k)}}}, 4);
      if (k <= ACTIVE_LINES) expect_row({4{8'(k)}});
    end
    check_outputs("R8 active line limit");
  endtask

  task automatic t_backpressure();
    logic [WORD_W-1:0] first;
    cmd_stop();
    cmd_start(4'd1);
    new_field();
    send_line(40'h00FFFFFFFF, 4);
    @(negedge clk);
    out_ready = 1'b0;
    send_line(40'h00D4C3B2A1, 4);
    tick(2);
    #1;
    check_eq("R10 valid while stalled", out_valid, 1);
    first = out_word;
    tick(4);
    #1;
    check_eq("R10 word held under stall", out_word, first);
    check_eq("R10 first word in order", first, 8'hA1);
    @(negedge clk);
    out_ready = 1'b1;
    expect_row(32'hD4C3B2A1);
    check_outputs("R10 full row after stall");
    send_line(40'h5544332211, 5);
    expect_row(32'h44332211);
    check_outputs("R11 extra word ignored");
  endtask

  task automatic t_stop();
    cmd_stop();
    send_line(40'h0099999999, 4);
    send_line(40'h0077777777, 4);
    check_outputs("R2 stop gives nothing");
    check_eq("R2 valid low after stop", out_valid, 0);
  endtask

  task automatic t_zero_lpe();
    cmd_start(4'd0);
    new_field();
    send_line(40'h00FFFFFFFF, 4);
    send_line(40'h0001020304, 4);
    send_line(40'h0010203040, 4);
    expect_row(32'h01020304);
    expect_row(32'h10203040);
    check_outputs("R5 zero treated as one");
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    t_reset();
    t_wait_for_field();
    t_single_lines();
    t_skipped_field();
    t_pairs();
    t_line_limit();
    t_backpressure();
    t_stop();
    t_zero_lpe();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule